// File: doc/BRIEF.md
# Total-Store-Order Store Buffer

This block sits between one core's load/store pipeline and a single-port data cache. Committed stores are placed in a first-in first-out queue and are written to the cache strictly oldest first. Loads do not wait for that queue to empty. A load to an address that no queued store holds completes at once, even while the oldest store is stuck on a cache write miss. A load to an address that a queued store does hold gets the value of the youngest such store. The result is total store order: a load may overtake an older store to a different address, but a store never overtakes a store, and a load never overtakes a store to its own address.

Three fence requests let software restore stronger ordering. A load fence holds back later loads. A store fence holds back later stores. A full fence holds back both. Each fence lasts until every store older than it has drained. Stores and the drain port use valid/ready handshakes. A store is transferred only in a cycle where `st_valid` and `st_ready` are both high. While `st_ready` is low, the producer must keep the store's address, data and byte enables steady. A drain beat completes only when `dr_valid` and `dr_ready` are high and `cache_miss` is low. The load side is a valid/ready request with a combinational answer: in the cycle a load is accepted, `ld_hit` and `ld_data` report whether the buffer supplies the word.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the buffer is empty. `dr_valid` is 0, and `st_ready`, `ld_ready` and `fence_ready` are 1.
- R2: Stores leave on the drain port in exactly the order they were accepted, with their address, data and byte enables unchanged. `dr_valid` is high exactly when at least one store is held.
- R3: When DEPTH stores are held, `st_ready` is 0 and no further store is accepted.
- R4: While `cache_miss` is high, the head entry stays on the drain port unchanged and is not removed.
- R5: A load whose word address matches no held store is accepted with `ld_hit`=0 whatever the state of the drain port, including during a cache miss.
- R6: A load whose youngest matching held store has all four byte enables set (`4'hF`) is accepted with `ld_hit`=1 and that store's data. A store accepted in the same cycle as the load is not visible to it.
- R7: A load whose youngest matching held store has a partial byte-enable mask sees `ld_ready`=0 until that store has drained.
- R8: A store fence (`fence_kind`=2) keeps `st_ready` at 0 from the next cycle until every store accepted up to and including its own cycle has drained. Loads are not affected.
- R9: A load fence (`fence_kind`=1) keeps `ld_ready` at 0 from the next cycle until every store accepted up to and including its own cycle has drained. Stores are still accepted.
- R10: A full fence (`fence_kind`=3) holds both `st_ready` and `ld_ready` at 0 over the same window.
- R11: `fence_ready` is 0 while a fence is waiting. A fence accepted when no older store remains after that cycle ends at once. `fence_kind`=0 is accepted and has no effect.
- R12: A store accepted in the same cycle as a fence counts as older than the fence, so the fence also waits for that store to drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Committed store offered |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| ld_valid | input | 1 | Load request offered |
| ld_ready | output | 1 | Load can complete this cycle |
| ld_addr | input | AW | Load word address |
| ld_hit | output | 1 | Buffer supplies the load data |
| ld_data | output | 32 | Forwarded data, meaningful when ld_hit |
| fence_valid | input | 1 | Fence request offered |
| fence_ready | output | 1 | No fence is waiting; a fence can be taken |
| fence_kind | input | 2 | 0 none, 1 load, 2 store, 3 full |
| dr_valid | output | 1 | Head store offered to cache |
| dr_ready | input | 1 | Cache port can take a write |
| cache_miss | input | 1 | Cache write missed; keep head in place |
| dr_addr | output | AW | Head store word address |
| dr_data | output | 32 | Head store data |
| dr_be | output | 4 | Head store byte enables |

## Verification
The hardest state to reach is the one where a partial-mask store is the youngest match for a load. Often a fence is pending at the same time, and the head store keeps missing in the cache, so that a load stall and a fence stall overlap and then clear one after the other. The stimulus gets there in phases. It keeps the addresses in a four-word window so that matches are frequent, and it weights stores with partial masks. It holds `cache_miss` high for long stretches with fences arriving often, and other phases first fill the buffer and then let it drain. A queue-based reference model predicts every ready, hit and drain output on every cycle.

// File: rtl/tsob_pkg.sv
`timescale 1ns/1ps
package tsob_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  // fence request encodings; bit 0 gates loads, bit 1 gates stores
  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_LOAD  = 2'd1,
    FK_STORE = 2'd2,
    FK_FULL  = 2'd3
  } fence_kind_e;

  localparam int unsigned FK_LD_BIT = 0;
  localparam int unsigned FK_ST_BIT = 1;
endpackage

// File: rtl/sb_queue.sv
`timescale 1ns/1ps
module sb_queue
  import tsob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 30,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DATA_W-1:0]            push_data,
  input  logic [BE_W-1:0]              push_be,
  input  logic                         pop,
  output logic [IW-1:0]                head,
  output logic [CW-1:0]                count,
  output logic [DEPTH-1:0][AW-1:0]     slot_addr,
  output logic [DEPTH-1:0][DATA_W-1:0] slot_data,
  output logic [DEPTH-1:0][BE_W-1:0]   slot_be
);
  logic [IW-1:0] tail;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    if (int'(p) == int'(DEPTH) - 1) step = '0;
    else                            step = p + IW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // payload storage carries no reset: slots are only read below count
  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail] <= push_addr;
      slot_data[tail] <= push_data;
      slot_be[tail]   <= push_be;
    end
  end
endmodule

// File: rtl/sb_fwd.sv
`timescale 1ns/1ps
module sb_fwd
  import tsob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 30,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0]                ld_addr,
  input  logic [IW-1:0]                head,
  input  logic [CW-1:0]                count,
  input  logic [DEPTH-1:0][AW-1:0]     slot_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
  input  logic [DEPTH-1:0][BE_W-1:0]   slot_be,
  output logic                         fwd_hit,
  output logic                         fwd_stall,
  output logic [DATA_W-1:0]            fwd_data
);
  logic              found;
  logic [BE_W-1:0]   found_be;
  logic [DATA_W-1:0] found_data;

  // walk from oldest to youngest; the last match wins
  always_comb begin
    found      = 1'b0;
    found_be   = '0;
    found_data = '0;
    for (int age = 0; age < int'(DEPTH); age++) begin
      int pos;
      pos = int'(head) + age;
      if (pos >= int'(DEPTH)) pos = pos - int'(DEPTH);
      if (age < int'(count) && slot_addr[IW'(pos)] == ld_addr) begin
        found      = 1'b1;
        found_be   = slot_be[IW'(pos)];
        found_data = slot_data[IW'(pos)];
      end
    end
  end

  assign fwd_hit   = found && (&found_be);
  assign fwd_stall = found && !(&found_be);
  assign fwd_data  = fwd_hit ? found_data : '0;
endmodule

// File: rtl/sb_fence.sv
`timescale 1ns/1ps
module sb_fence
  import tsob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fence_fire,
  input  logic [1:0]    fence_kind,
  input  logic [CW-1:0] count_after,
  input  logic          drain_fire,
  output logic          fence_idle,
  output logic          hold_stores,
  output logic          hold_loads
);
  logic          pend;
  fence_kind_e   kind_q;
  logic [CW-1:0] older_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      kind_q     <= FK_NONE;
      older_left <= '0;
    end else if (!pend) begin
      if (fence_fire && fence_kind != FK_NONE && count_after != '0) begin
        pend       <= 1'b1;
        kind_q     <= fence_kind_e'(fence_kind);
        older_left <= count_after;
      end
    end else if (drain_fire) begin
      older_left <= older_left - CW'(1);
      if (older_left == CW'(1)) pend <= 1'b0;
    end
  end

  assign fence_idle  = !pend;
  assign hold_stores = pend && kind_q[FK_ST_BIT];
  assign hold_loads  = pend && kind_q[FK_LD_BIT];
endmodule

// File: rtl/tso_store_buffer.sv
`timescale 1ns/1ps
module tso_store_buffer
  import tsob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [AW-1:0]     st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [AW-1:0]     ld_addr,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  input  logic              fence_valid,
  output logic              fence_ready,
  input  logic [1:0]        fence_kind,
  output logic              dr_valid,
  input  logic              dr_ready,
  input  logic              cache_miss,
  output logic [AW-1:0]     dr_addr,
  output logic [DATA_W-1:0] dr_data,
  output logic [BE_W-1:0]   dr_be
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [IW-1:0]                head;
  logic [CW-1:0]                count;
  logic [CW-1:0]                count_after;
  logic [DEPTH-1:0][AW-1:0]     slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic [DEPTH-1:0][BE_W-1:0]   slot_be;
  logic st_fire, drain_fire, fence_fire;
  logic hold_stores, hold_loads, fwd_stall, fwd_hit;
  logic [DATA_W-1:0] fwd_data;

  assign st_ready    = (count != CW'(DEPTH)) && !hold_stores;
  assign st_fire     = st_valid && st_ready;
  assign dr_valid    = (count != '0);
  assign drain_fire  = dr_valid && dr_ready && !cache_miss;
  assign fence_fire  = fence_valid && fence_ready;
  assign count_after = count + CW'(st_fire) - CW'(drain_fire);

  assign dr_addr = slot_addr[head];
  assign dr_data = slot_data[head];
  assign dr_be   = slot_be[head];

  assign ld_ready = !hold_loads && !fwd_stall;
  assign ld_hit   = fwd_hit;
  assign ld_data  = fwd_data;

  sb_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(st_fire), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
    .pop(drain_fire), .head(head), .count(count),
    .slot_addr(slot_addr), .slot_data(slot_data), .slot_be(slot_be)
  );

  sb_fwd #(.DEPTH(DEPTH), .AW(AW)) u_fwd (
    .ld_addr(ld_addr), .head(head), .count(count),
    .slot_addr(slot_addr), .slot_data(slot_data), .slot_be(slot_be),
    .fwd_hit(fwd_hit), .fwd_stall(fwd_stall), .fwd_data(fwd_data)
  );

  sb_fence #(.DEPTH(DEPTH)) u_fence (
    .clk(clk), .rst_n(rst_n),
    .fence_fire(fence_fire), .fence_kind(fence_kind),
    .count_after(count_after), .drain_fire(drain_fire),
    .fence_idle(fence_ready), .hold_stores(hold_stores), .hold_loads(hold_loads)
  );
endmodule

// File: rtl/tso_store_buffer_chk.sv
`timescale 1ns/1ps
module tso_store_buffer_chk
  import tsob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              ld_ready,
  input logic              fence_valid,
  input logic              fence_ready,
  input logic [1:0]        fence_kind,
  input logic              dr_valid,
  input logic              dr_ready,
  input logic              cache_miss,
  input logic [AW-1:0]     dr_addr,
  input logic [DATA_W-1:0] dr_data,
  input logic [BE_W-1:0]   dr_be
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ;
  logic [CW-1:0] occ_next;
  logic          s_fire, d_fire, f_fire;

  assign s_fire   = st_valid && st_ready;
  assign d_fire   = dr_valid && dr_ready && !cache_miss;
  assign f_fire   = fence_valid && fence_ready;
  assign occ_next = occ + CW'(s_fire) - CW'(d_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_next;
  end

  AST_EMPTY_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !dr_valid);  // R1
  AST_HELD_HAS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) |-> dr_valid);  // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !st_ready);  // R3
  AST_HEAD_HELD_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && cache_miss) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data) && $stable(dr_be)));  // R4
  AST_STORE_FENCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_fire && fence_kind == FK_STORE && occ_next != '0) |=> !st_ready);  // R8
  AST_LOAD_FENCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_fire && fence_kind == FK_LOAD && occ_next != '0) |=> !ld_ready);  // R9
  AST_FULL_FENCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_fire && fence_kind == FK_FULL && occ_next != '0) |=> (!ld_ready && !st_ready));  // R10
  AST_FENCE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (f_fire && fence_kind != FK_NONE && occ_next != '0) |=> !fence_ready);  // R11
endmodule

bind tso_store_buffer tso_store_buffer_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .ld_ready(ld_ready), .fence_valid(fence_valid), .fence_ready(fence_ready),
  .fence_kind(fence_kind), .dr_valid(dr_valid), .dr_ready(dr_ready),
  .cache_miss(cache_miss), .dr_addr(dr_addr), .dr_data(dr_data), .dr_be(dr_be)
);

// File: tb/tso_store_buffer_tb_top.sv
`timescale 1ns/1ps
module tso_store_buffer_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, ld_valid = 1'b0, fence_valid = 1'b0;
  logic dr_ready = 1'b0, cache_miss = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic [1:0]  fence_kind = '0;
  logic st_ready, ld_ready, ld_hit, fence_ready, dr_valid;
  logic [31:0] ld_data, dr_data;
  logic [AW-1:0] dr_addr;
  logic [3:0] dr_be;

  always #4 clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .fence_valid(fence_valid), .fence_ready(fence_ready), .fence_kind(fence_kind),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .cache_miss(cache_miss),
    .dr_addr(dr_addr), .dr_data(dr_data), .dr_be(dr_be)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [3:0]    b;
  } ent_t;

  ent_t q[$];
  bit   m_pend = 0;
  logic [1:0] m_kind = 0;
  int   m_left = 0;
  int   total = 0, bad = 0;
  bit   e_sr, e_lr, e_hit, e_dv, e_fr;
  logic [31:0] e_ldd;
  int   p_st, p_dr, p_miss, p_fence, p_ld, p_part;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic predict();
    int youngest;
    youngest = -1;
    for (int i = 0; i < q.size(); i++) if (q[i].a == ld_addr) youngest = i;
    e_dv  = q.size() > 0;
    e_sr  = (q.size() < DEPTH) && !(m_pend && m_kind[1]);
    e_fr  = !m_pend;
    e_lr  = !(m_pend && m_kind[0]) && !(youngest >= 0 && q[youngest].b != 4'hF);
    e_hit = (youngest >= 0) && q[youngest].b == 4'hF;
    e_ldd = e_hit ? q[youngest].d : 32'h0;
  endtask

  task automatic compare();
    predict();
    chk(st_ready == e_sr, "R3/R8/R10 st_ready", 64'(st_ready), 64'(e_sr));
    chk(ld_ready == e_lr, "R5/R7/R9 ld_ready", 64'(ld_ready), 64'(e_lr));
    chk(fence_ready == e_fr, "R11/R12 fence_ready", 64'(fence_ready), 64'(e_fr));
    chk(dr_valid == e_dv, "R2 dr_valid", 64'(dr_valid), 64'(e_dv));
    if (ld_valid && e_lr) begin
      chk(ld_hit == e_hit, "R5/R6 ld_hit", 64'(ld_hit), 64'(e_hit));
      if (e_hit) chk(ld_data == e_ldd, "R6 ld_data", 64'(ld_data), 64'(e_ldd));
    end
    if (e_dv)
      chk({dr_addr, dr_data, dr_be} == {q[0].a, q[0].d, q[0].b}, "R2/R4 drain head",
          64'({dr_addr, dr_data, dr_be}), 64'({q[0].a, q[0].d, q[0].b}));
  endtask

  task automatic advance();
    bit sf, df, ff;
    int after;
    sf = st_valid && e_sr;
    df = e_dv && dr_ready && !cache_miss;
    ff = fence_valid && e_fr;
    after = q.size() + int'(sf) - int'(df);
    if (m_pend) begin
      if (df) begin
        m_left--;
        if (m_left == 0) m_pend = 0;
      end
    end else if (ff && fence_kind != 2'd0 && after != 0) begin
      m_pend = 1; m_kind = fence_kind; m_left = after;
    end
    if (df) void'(q.pop_front());
    if (sf) q.push_back('{a: st_addr, d: st_data, b: st_be});
  endtask

  task automatic drive();
    if (!(st_valid && !e_sr) || ($urandom_range(99) < 5 && 1'b0)) begin
      st_valid = ($urandom_range(99) < p_st);
      st_addr  = AW'($urandom_range(3));
      st_data  = $urandom;
      st_be    = ($urandom_range(99) < p_part) ? 4'($urandom_range(14, 1)) : 4'hF;
    end
    ld_valid    = ($urandom_range(99) < p_ld);
    ld_addr     = ($urandom_range(99) < 10) ? AW'($urandom_range(100, 4)) : AW'($urandom_range(3));
    dr_ready    = ($urandom_range(99) < p_dr);
    cache_miss  = ($urandom_range(99) < p_miss);
    fence_valid = ($urandom_range(99) < p_fence);
    fence_kind  = 2'($urandom_range(3));
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!dr_valid, "R1 dr_valid", 64'(dr_valid), 64'(0));
    chk(st_ready && ld_ready && fence_ready, "R1 ready set", 64'({st_ready, ld_ready, fence_ready}), 64'(7));
    predict();
    for (int ph = 0; ph < 6; ph++) begin
      case (ph)
        0: begin p_st = 90; p_dr = 5;  p_miss = 0;  p_fence = 0;  p_ld = 60; p_part = 10; end // R3 fill
        1: begin p_st = 50; p_dr = 90; p_miss = 75; p_fence = 0;  p_ld = 80; p_part = 10; end // R4 R5
        2: begin p_st = 60; p_dr = 60; p_miss = 20; p_fence = 5;  p_ld = 80; p_part = 40; end // R6 R7
        3: begin p_st = 60; p_dr = 50; p_miss = 30; p_fence = 30; p_ld = 60; p_part = 20; end // R8 R9 R10 R12
        4: begin p_st = 70; p_dr = 40; p_miss = 60; p_fence = 15; p_ld = 70; p_part = 30; end
        default: begin p_st = 40; p_dr = 80; p_miss = 10; p_fence = 10; p_ld = 50; p_part = 25; end
      endcase
      for (int c = 0; c < 3000; c++) begin
        @(posedge clk);
        advance();
        #1 drive();
        @(negedge clk);
        compare();
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule